// File: doc/BRIEF.md
# Parallel ADC Host Bus Controller

This block sits on the host side of a byte-wide parallel link to a 10-bit, multi-channel analog-to-digital converter. When it receives a start request, it runs one complete conversion transaction. It writes a configuration byte supplied by the user, using an active-low chip select and write strobe. The rising edge of that write starts the conversion. In external-acquisition mode a second write follows, and its rising edge closes the acquisition window.

The block then waits for the converter's active-low completion flag. It brings that flag into its own clock domain through a two-flop synchronizer. When the flag is low, the block performs two byte reads with the read strobe: the low byte first with the byte-select line low, then the upper two bits with byte-select high. It joins the two bytes into a 10-bit word and flags that word with a one-cycle valid pulse.

The data bus is bidirectional on the board. The block drives it through a separate output, input and output-enable, and enables the output only while a write access is open. If the completion flag never arrives, a timeout returns the controller to idle and raises an error flag.

Top module: `adc_bus_ctrl`

## Requirements
- R1: After reset, chip select, write strobe and read strobe are all high (inactive), output-enable is 0, and busy, result-valid and error are 0.
- R2: A start request is accepted only while busy is low. An accepted start latches the configuration byte and the mode input, and busy rises on the following cycle. A start raised while busy has no effect on the bytes written, on the number of writes, or on the result.
- R3: Every bus access does the following:
  - chip select falls one cycle before its strobe falls;
  - the strobe stays low for STROBE_CYC cycles;
  - chip select stays low for one cycle after the strobe rises, then stays high for at least GAP_CYC cycles.
- R4: On a write access, the bus carries the latched configuration byte and output-enable is 1 for the whole chip-select-low window. With mode input 0 (internal acquisition), a transaction has one write. With mode input 1 (external acquisition), it has two writes, and both carry the configuration byte.
- R5: No read strobe falls before the completion flag is low. The first read strobe falls no earlier than the fourth clock edge after the flag is seen low, because of the two-flop synchronizer.
- R6: A transaction makes exactly two reads. The first has byte-select 0 and captures result bits 7..0 from bus bits 7..0. The second has byte-select 1 and captures result bits 9..8 from bus bits 1..0. Byte-select stays constant while the read strobe is low. Bus data is sampled on the last cycle of the read strobe.
- R7: After the second read, result-valid is high for exactly one cycle, in the cycle where busy returns low. The result output then equals {second byte[1:0], first byte[7:0]}.
- R8: If the completion flag stays high for TIMEOUT_CYC cycles of waiting, the controller returns to idle with the error flag at 1, without reading and without a valid pulse. The error flag stays at 1 until the next accepted start clears it.
- R9: Output-enable is 1 only while chip select is low and the read strobe is high. The write and read strobes are never low together. Neither strobe is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-request pulse |
| cfg_i | input | 8 | Configuration byte to write |
| ext_acq_i | input | 1 | 1 = external acquisition (two writes), 0 = internal |
| busy_o | output | 1 | Transaction in progress |
| result_o | output | 10 | Assembled conversion result |
| result_valid_o | output | 1 | One-cycle pulse when result_o is new |
| timeout_err_o | output | 1 | Completion-flag timeout occurred |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_wr_n_o | output | 1 | Converter write strobe, active low |
| adc_rd_n_o | output | 1 | Converter read strobe, active low |
| adc_hben_o | output | 1 | Byte select: 0 low byte, 1 upper bits |
| adc_bus_o | output | 8 | Data driven toward the converter |
| adc_bus_oe_o | output | 1 | Enable for the bus output driver |
| adc_bus_i | input | 8 | Data read from the bus |
| adc_done_n_i | input | 1 | Converter completion flag, active low |

## Verification
The assertions check the bus safety rules on every cycle:
- output-enable only inside a chip-select window with the read strobe high;
- no overlapping strobes and no strobe outside chip select;
- chip-select lead and lag around the strobes;
- byte-select held steady during a read;
- result-valid is a single pulse that coincides with idle, as does the rise of the error flag.

The bench scenarios are needed for the properties that depend on the converter's behaviour:
- the configuration byte seen at each write edge;
- one write versus two writes for each mode;
- the latency from the completion flag to the first read;
- the byte order and the assembled value for several data patterns;
- starts ignored while busy;
- the timeout and its clearing.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_GAP,
        ST_WAIT
    } st_e;

    typedef enum logic [1:0] {
        OP_CFG,
        OP_TRIG,
        OP_RDLO,
        OP_RDHI
    } op_e;

    function automatic logic op_is_write(op_e op);
        return (op == OP_CFG) || (op == OP_TRIG);
    endfunction

endpackage

// File: rtl/adc_sync2.sv
module adc_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [1:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {2{RST_VAL}};
        else        stg_q <= stg_d;
    end

    assign sync_o = stg_q[1];
endmodule

// File: rtl/adc_wait_timer.sv
module adc_wait_timer #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int TW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)                     cnt_d = TW'(LIMIT - 1);
        else if (run_i && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/adc_result_join.sv
module adc_result_join #(
    parameter int BUS_W = 8,
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_lo_i,
    input  logic             cap_hi_i,
    input  logic [BUS_W-1:0] bus_i,
    output logic [RES_W-1:0] result_o
);
    localparam int HI_W = RES_W - BUS_W;

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [BUS_W-1:0] lo;
    } join_t;

    join_t j_d, j_q;

    always_comb begin
        j_d = j_q;
        if (cap_lo_i) j_d.lo = bus_i;
        if (cap_hi_i) j_d.hi = bus_i[HI_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) j_q <= '0;
        else        j_q <= j_d;
    end

    assign result_o = {j_q.hi, j_q.lo};
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
    import adc_bus_pkg::*;
#(
    parameter int BUS_W       = 8,
    parameter int RES_W       = 10,
    parameter int STROBE_CYC  = 2,
    parameter int GAP_CYC     = 2,
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [BUS_W-1:0] cfg_i,
    input  logic             ext_acq_i,
    output logic             busy_o,
    output logic [RES_W-1:0] result_o,
    output logic             result_valid_o,
    output logic             timeout_err_o,
    output logic             adc_cs_n_o,
    output logic             adc_wr_n_o,
    output logic             adc_rd_n_o,
    output logic             adc_hben_o,
    output logic [BUS_W-1:0] adc_bus_o,
    output logic             adc_bus_oe_o,
    input  logic [BUS_W-1:0] adc_bus_i,
    input  logic             adc_done_n_i
);
    localparam int CNT_MAX = (STROBE_CYC > GAP_CYC) ? STROBE_CYC : GAP_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        st_e              state;
        op_e              op;
        logic [CNT_W-1:0] cnt;
        logic [BUS_W-1:0] cfg;
        logic             ext;
        logic             cs_n;
        logic             wr_n;
        logic             rd_n;
        logic             hben;
        logic             oe;
        logic             valid;
        logic             err;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        state: ST_IDLE, op: OP_CFG, cnt: '0, cfg: '0, ext: 1'b0,
        cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1, hben: 1'b0, oe: 1'b0,
        valid: 1'b0, err: 1'b0
    };

    ctl_t c_d, c_q;
    logic done_n_s;
    logic tmr_load;
    logic tmr_expired;
    logic cap_lo;
    logic cap_hi;
    logic in_access;

    adc_sync2 #(.RST_VAL(1'b1)) u_done_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (adc_done_n_i),
        .sync_o  (done_n_s)
    );

    adc_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .run_i     (c_q.state == ST_WAIT),
        .expired_o (tmr_expired)
    );

    adc_result_join #(.BUS_W(BUS_W), .RES_W(RES_W)) u_join (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_lo_i (cap_lo),
        .cap_hi_i (cap_hi),
        .bus_i    (adc_bus_i),
        .result_o (result_o)
    );

    always_comb begin
        c_d       = c_q;
        c_d.valid = 1'b0;
        tmr_load  = 1'b0;
        cap_lo    = 1'b0;
        cap_hi    = 1'b0;

        unique case (c_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    c_d.state = ST_SETUP;
                    c_d.op    = OP_CFG;
                    c_d.cfg   = cfg_i;
                    c_d.ext   = ext_acq_i;
                    c_d.err   = 1'b0;
                end
            end
            ST_SETUP: begin
                c_d.state = ST_STROBE;
                c_d.cnt   = CNT_W'(STROBE_CYC - 1);
            end
            ST_STROBE: begin
                if (c_q.cnt == '0) begin
                    c_d.state = ST_HOLD;
                    cap_lo    = (c_q.op == OP_RDLO);
                    cap_hi    = (c_q.op == OP_RDHI);
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end
            ST_HOLD: begin
                c_d.state = ST_GAP;
                c_d.cnt   = CNT_W'(GAP_CYC - 1);
            end
            ST_GAP: begin
                if (c_q.cnt != '0) begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end else begin
                    unique case (c_q.op)
                        OP_CFG: begin
                            if (c_q.ext) begin
                                c_d.state = ST_SETUP;
                                c_d.op    = OP_TRIG;
                            end else begin
                                c_d.state = ST_WAIT;
                                tmr_load  = 1'b1;
                            end
                        end
                        OP_TRIG: begin
                            c_d.state = ST_WAIT;
                            tmr_load  = 1'b1;
                        end
                        OP_RDLO: begin
                            c_d.state = ST_SETUP;
                            c_d.op    = OP_RDHI;
                        end
                        OP_RDHI: begin
                            c_d.state = ST_IDLE;
                            c_d.valid = 1'b1;
                        end
                        default: c_d.state = ST_IDLE;
                    endcase
                end
            end
            ST_WAIT: begin
                if (!done_n_s) begin
                    c_d.state = ST_SETUP;
                    c_d.op    = OP_RDLO;
                end else if (tmr_expired) begin
                    c_d.state = ST_IDLE;
                    c_d.err   = 1'b1;
                end
            end
            default: c_d.state = ST_IDLE;
        endcase

        // Pin levels follow the next state, so the outputs leave a flop
        in_access = (c_d.state == ST_SETUP) || (c_d.state == ST_STROBE) ||
                    (c_d.state == ST_HOLD);
        c_d.cs_n  = !in_access;
        c_d.wr_n  = !((c_d.state == ST_STROBE) && op_is_write(c_d.op));
        c_d.rd_n  = !((c_d.state == ST_STROBE) && !op_is_write(c_d.op));
        c_d.oe    = in_access && op_is_write(c_d.op);
        c_d.hben  = (c_d.op == OP_RDHI) && (c_d.state != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= CTL_RST;
        else        c_q <= c_d;
    end

    assign busy_o         = (c_q.state != ST_IDLE);
    assign result_valid_o = c_q.valid;
    assign timeout_err_o  = c_q.err;
    assign adc_cs_n_o     = c_q.cs_n;
    assign adc_wr_n_o     = c_q.wr_n;
    assign adc_rd_n_o     = c_q.rd_n;
    assign adc_hben_o     = c_q.hben;
    assign adc_bus_oe_o   = c_q.oe;
    assign adc_bus_o      = c_q.cfg;
endmodule

// File: rtl/adc_bus_ctrl_sva.sv
module adc_bus_ctrl_sva (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic result_valid_o,
    input logic timeout_err_o,
    input logic adc_cs_n_o,
    input logic adc_wr_n_o,
    input logic adc_rd_n_o,
    input logic adc_hben_o,
    input logic adc_bus_oe_o
);
    assert_bus_drive_safe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        adc_bus_oe_o |-> (!adc_cs_n_o && adc_rd_n_o));

    assert_no_dual_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!adc_wr_n_o && !adc_rd_n_o));

    assert_strobe_in_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_wr_n_o || !adc_rd_n_o) |-> !adc_cs_n_o);

    assert_cs_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n_o) |-> (adc_wr_n_o && adc_rd_n_o));

    assert_cs_lag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(adc_wr_n_o) || $rose(adc_rd_n_o)) |-> !adc_cs_n_o);

    assert_hben_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_rd_n_o && $past(!adc_rd_n_o)) |-> $stable(adc_hben_o));

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |=> !result_valid_o);

    assert_valid_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |-> !busy_o);

    assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err_o) |-> !busy_o);
endmodule

bind adc_bus_ctrl adc_bus_ctrl_sva u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy_o         (busy_o),
    .result_valid_o (result_valid_o),
    .timeout_err_o  (timeout_err_o),
    .adc_cs_n_o     (adc_cs_n_o),
    .adc_wr_n_o     (adc_wr_n_o),
    .adc_rd_n_o     (adc_rd_n_o),
    .adc_hben_o     (adc_hben_o),
    .adc_bus_oe_o   (adc_bus_oe_o)
);

// File: tb/sim_adc_bus_ctrl.sv
module sim_adc_bus_ctrl;
    localparam int STRB = 2;
    localparam int GAP  = 2;
    localparam int TMO  = 4096;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] cfg_i = '0;
    logic       ext_acq_i = 1'b0;
    logic       busy_o, result_valid_o, timeout_err_o;
    logic [9:0] result_o;
    logic       adc_cs_n_o, adc_wr_n_o, adc_rd_n_o, adc_hben_o, adc_bus_oe_o;
    logic [7:0] adc_bus_o, adc_bus_i;
    logic       done_n = 1'b1;

    // converter model state
    logic [7:0] m_cfg = '0;
    logic       m_ext = 1'b0;
    logic [9:0] m_smp = '0;
    int         m_dly = 1;
    bit         m_no_done = 1'b0;
    int         conv_cnt = 0, done_age = 0, wr_w = 0, rd_w = 0;
    int         wr_cnt = 0, rd_cnt = 0, wr_in_txn = 0;
    logic       prev_wr = 1'b1, prev_rd = 1'b1, prev_cs = 1'b1, prev_busy = 1'b0;
    logic [9:0] exp_q[$];

    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    adc_bus_ctrl #(.STROBE_CYC(STRB), .GAP_CYC(GAP), .TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_i(cfg_i),
        .ext_acq_i(ext_acq_i), .busy_o(busy_o), .result_o(result_o),
        .result_valid_o(result_valid_o), .timeout_err_o(timeout_err_o),
        .adc_cs_n_o(adc_cs_n_o), .adc_wr_n_o(adc_wr_n_o), .adc_rd_n_o(adc_rd_n_o),
        .adc_hben_o(adc_hben_o), .adc_bus_o(adc_bus_o), .adc_bus_oe_o(adc_bus_oe_o),
        .adc_bus_i(adc_bus_i), .adc_done_n_i(done_n)
    );

    assign adc_bus_i = (!adc_cs_n_o && !adc_rd_n_o)
                     ? (adc_hben_o ? {6'b0, m_smp[9:8]} : m_smp[7:0]) : 8'hA5;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // converter model and monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_o && !prev_busy) wr_in_txn = 0;
            if (!done_n) done_age++;
            if (conv_cnt != 0) begin
                conv_cnt--;
                if (conv_cnt == 0) begin done_n = 1'b0; done_age = 0; end
            end
            if (!adc_wr_n_o) wr_w++;
            if (prev_wr && !adc_wr_n_o)
                chk(prev_cs == 1'b0, "R3 cs lead before write", prev_cs, 0);
            if (!prev_wr && adc_wr_n_o) begin
                chk(wr_w == STRB, "R3 write strobe width", wr_w, STRB);
                wr_w = 0;
                chk(!adc_cs_n_o, "R3 cs held after write", adc_cs_n_o, 0);
                chk(adc_bus_oe_o && adc_bus_o == m_cfg, "R4 cfg byte on write edge",
                    {adc_bus_oe_o, adc_bus_o}, {1'b1, m_cfg});
                wr_cnt++;
                wr_in_txn++;
                if ((!m_ext || wr_in_txn == 2) && !m_no_done) conv_cnt = m_dly;
            end
            if (!adc_rd_n_o) rd_w++;
            if (prev_rd && !adc_rd_n_o) begin
                chk(prev_cs == 1'b0, "R3 cs lead before read", prev_cs, 0);
                chk(adc_hben_o == rd_cnt[0], "R6 byte select order", adc_hben_o, rd_cnt[0]);
                if (!rd_cnt[0]) begin
                    chk(!done_n, "R5 read before done", done_n, 0);
                    chk(done_age >= 4, "R5 sync latency", done_age, 4);
                    done_n = 1'b1;
                end
            end
            if (!prev_rd && adc_rd_n_o) begin
                chk(rd_w == STRB, "R6 read strobe width", rd_w, STRB);
                rd_w = 0;
                rd_cnt++;
            end
            if (result_valid_o) begin
                if (exp_q.size() == 0) chk(1'b0, "R7 unexpected valid", 1, 0);
                else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    chk(result_o == e, "R7 assembled result", result_o, e);
                end
            end
        end
        prev_wr = adc_wr_n_o;
        prev_rd = adc_rd_n_o;
        prev_cs = adc_cs_n_o;
        prev_busy = busy_o;
    end

    task automatic run_conv(input logic [7:0] cfg, input bit ext, input logic [9:0] smp,
                            input int dly, input bit nodone, input bit poke);
        int wr0, rd0, cyc;
        m_cfg = cfg; m_ext = ext; m_smp = smp; m_dly = dly; m_no_done = nodone;
        wr0 = wr_cnt; rd0 = rd_cnt;
        if (!nodone) exp_q.push_back(smp);
        @(negedge clk); start_i = 1'b1; cfg_i = cfg; ext_acq_i = ext;
        @(negedge clk); start_i = 1'b0;
        chk(busy_o, "R2 start accepted", busy_o, 1);
        chk(!timeout_err_o, "R8 error cleared by start", timeout_err_o, 0);
        if (poke) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1; cfg_i = ~cfg; ext_acq_i = !ext;
            @(negedge clk); start_i = 1'b0;
        end
        cyc = 0;
        while (busy_o) begin @(negedge clk); cyc++; end
        chk(wr_cnt - wr0 == (ext ? 2 : 1), poke ? "R2 busy start ignored" : "R4 write count",
            wr_cnt - wr0, ext ? 2 : 1);
        chk(rd_cnt - rd0 == (nodone ? 0 : 2), "R6 read count", rd_cnt - rd0, nodone ? 0 : 2);
        if (nodone) begin
            chk(timeout_err_o, "R8 error raised", timeout_err_o, 1);
            chk(cyc >= TMO, "R8 timeout length", cyc, TMO);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({adc_cs_n_o, adc_wr_n_o, adc_rd_n_o} == 3'b111, "R1 strobes idle",
            {adc_cs_n_o, adc_wr_n_o, adc_rd_n_o}, 3'b111);
        chk({adc_bus_oe_o, busy_o, result_valid_o, timeout_err_o} == 4'b0, "R1 flags idle",
            {adc_bus_oe_o, busy_o, result_valid_o, timeout_err_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_conv(8'h81, 1'b0, 10'h2A5, 5, 1'b0, 1'b0);
        run_conv(8'h3C, 1'b1, 10'h3FF, 8, 1'b0, 1'b0);
        run_conv(8'hFF, 1'b0, 10'h000, 1, 1'b0, 1'b0);
        run_conv(8'h00, 1'b1, 10'h155, 20, 1'b0, 1'b1);
        run_conv(8'h11, 1'b0, 10'h0AA, 1, 1'b1, 1'b0);
        chk(timeout_err_o, "R8 error held in idle", timeout_err_o, 1);
        run_conv(8'h22, 1'b0, 10'h1E7, 3, 1'b0, 1'b0);
        chk(!timeout_err_o, "R8 error stays clear", timeout_err_o, 0);
        chk(exp_q.size() == 0, "R7 all results delivered", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule